// File: doc/BRIEF.md
# Event Return Sequencer

This block sequences the four return-from-event operations of a processor core's event controller: leaving the emulation level, leaving the non-maskable interrupt level, leaving the exception level, and leaving an ordinary interrupt level. A return request names one of these four kinds. The block compares the kind with the current level, which it reads from the pending-level vector supplied by the owner of that vector. If the return is legal, it produces the new program counter from the matching saved return address and a revised pending vector for the owner to write back. If the return is not legal, it raises an illegal-resource exception strobe and changes nothing else.

The block also serves the two stack operations on the interrupt return register. Saving that register clears the global interrupt-disable bit of the pending vector and asks for a re-check of pending requests. Restoring it sets the global interrupt-disable bit. A strobe marks the cycle in which a return leaves no level active, so that the core can swap to the user stack pointer. The return-address registers and the stack-pointer swap are outside this block. All outputs are registered, and every result appears one clock after its request.

Top module: `evret_seq`

## Requirements
- R1: A return request while no pending bit other than bit 4 is set (user level) raises `exc_o` for one cycle and completes nothing.
- R2: The current level is the lowest-numbered set bit of `pend_i`, ignoring bit 4. Kind 0 (emulation) is legal only at level 0, kind 1 (NMI) only at level 2, and kind 2 (exception) only at level 3. Any other pairing raises `exc_o`.
- R3: Kind 3 (interrupt) is illegal at levels 0, 2 and 3 and at user level, and legal at level 1 and at levels 5 and above. When legal, the level it returns from is the current level.
- R4: Kind 0 reads `sav_emu_i`, kind 1 reads `sav_nmi_i`, kind 2 reads `sav_exc_i` and kind 3 reads `sav_int_i`.
- R5: One cycle after a legal return, `ret_done_o` pulses and `pc_o` holds the selected saved address with bit 0 forced to 0. `pc_o` keeps that value until the next legal return and is 0 before the first one.
- R6: If bit 0 of the selected saved address is 1, the pending bit of the level being left stays set in `pend_o`; otherwise it is cleared.
- R7: Every legal return clears bit 0 (emulation) of `pend_o`.
- R8: A legal return from level 1 or from level 5 or above clears bit 4 (global disable) in `pend_o`. Returns from levels 0, 2 and 3 copy bit 4 from `pend_i`.
- R9: A push request clears bit 4 of `pend_i` into `pend_o` and pulses `recheck_o`. A pop request sets bit 4 and does not pulse `recheck_o`. In both cases `pend_upd_o` pulses.
- R10: `to_user_o` pulses with `ret_done_o` exactly when the revised pending vector has no bit set other than bit 4.
- R11: Every legal return pulses `recheck_o` and `pend_upd_o` together with `ret_done_o`.
- R12: An illegal return leaves `pc_o` and `pend_o` unchanged, and among the strobes only `exc_o` pulses.
- R13: A return request takes precedence over push and pop in the same cycle, and push takes precedence over pop. The request that loses has no effect. With no request, all strobes are 0 and `pc_o` and `pend_o` hold their values.
- R14: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid_i | input | 1 | Return request for one cycle |
| ret_kind_i | input | 2 | Return kind: 0 emulation, 1 NMI, 2 exception, 3 interrupt |
| push_i | input | 1 | Interrupt return register saved to stack |
| pop_i | input | 1 | Interrupt return register restored from stack |
| pend_i | input | NUM_LEVELS | Current pending-level vector; bit 4 is the global disable |
| sav_emu_i | input | ADDR_W | Saved emulation return address |
| sav_nmi_i | input | ADDR_W | Saved NMI return address |
| sav_exc_i | input | ADDR_W | Saved exception return address |
| sav_int_i | input | ADDR_W | Saved interrupt return address |
| pc_o | output | ADDR_W | New program counter after the last legal return |
| pend_o | output | NUM_LEVELS | Revised pending vector to write back |
| pend_upd_o | output | 1 | `pend_o` is new this cycle |
| ret_done_o | output | 1 | Legal return completed |
| exc_o | output | 1 | Illegal-resource exception for a refused return |
| to_user_o | output | 1 | Return left no level active |
| recheck_o | output | 1 | Request to re-evaluate pending events |

## Verification
The assertions assume that `pend_i` is the vector the owner holds in the cycle of the request, and that each request lasts a single cycle. Push and pop are judged only when no return is requested in the same cycle. The bench drives each request for exactly one cycle on the falling edge. It builds pending vectors whose lowest set bit sweeps every level, including the empty vector for user level, with bit 4 and higher levels set at random. It also drives overlapping return, push and pop requests so that the precedence rules are covered.

// File: rtl/evret_pkg.sv
package evret_pkg;

    typedef enum logic [1:0] {
        RK_EMU = 2'd0,
        RK_NMI = 2'd1,
        RK_EXC = 2'd2,
        RK_INT = 2'd3
    } ret_kind_e;

    // Fixed level positions in the pending vector
    localparam int LV_EMU     = 0;
    localparam int LV_RST     = 1;
    localparam int LV_NMI     = 2;
    localparam int LV_EXC     = 3;
    localparam int LV_GDIS    = 4;
    localparam int LV_FIRST_G = 5;

endpackage

// File: rtl/evret_lvl_find.sv
module evret_lvl_find
    import evret_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-1:0] vec_i,
    output logic                  found_o,
    output logic [LVL_W-1:0]      idx_o
);

    // Lowest-numbered set bit wins; the global-disable bit is not a level
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (vec_i[i] && (i != LV_GDIS)) begin
                found_o = 1'b1;
                idx_o   = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/evret_legal.sv
module evret_legal
    import evret_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  ret_kind_e        kind_i,
    input  logic             found_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             legal_o,
    output logic [LVL_W-1:0] tgt_o
);

    localparam logic [LVL_W-1:0] L_EMU = LVL_W'(LV_EMU);
    localparam logic [LVL_W-1:0] L_NMI = LVL_W'(LV_NMI);
    localparam logic [LVL_W-1:0] L_EXC = LVL_W'(LV_EXC);

    always_comb begin
        legal_o = 1'b0;
        tgt_o   = lvl_i;
        unique case (kind_i)
            RK_EMU: begin
                tgt_o   = L_EMU;
                legal_o = found_i && (lvl_i == L_EMU);
            end
            RK_NMI: begin
                tgt_o   = L_NMI;
                legal_o = found_i && (lvl_i == L_NMI);
            end
            RK_EXC: begin
                tgt_o   = L_EXC;
                legal_o = found_i && (lvl_i == L_EXC);
            end
            RK_INT: begin
                tgt_o   = lvl_i;
                legal_o = found_i && (lvl_i != L_EMU) && (lvl_i != L_NMI)
                          && (lvl_i != L_EXC);
            end
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evret_src_sel.sv
module evret_src_sel
    import evret_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  ret_kind_e         kind_i,
    input  logic [ADDR_W-1:0] emu_i,
    input  logic [ADDR_W-1:0] nmi_i,
    input  logic [ADDR_W-1:0] exc_i,
    input  logic [ADDR_W-1:0] int_i,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        unique case (kind_i)
            RK_EMU:  addr_o = emu_i;
            RK_NMI:  addr_o = nmi_i;
            RK_EXC:  addr_o = exc_i;
            default: addr_o = int_i;
        endcase
    end

endmodule

// File: rtl/evret_seq.sv
module evret_seq
    import evret_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    parameter int ADDR_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ret_valid_i,
    input  logic [1:0]            ret_kind_i,
    input  logic                  push_i,
    input  logic                  pop_i,
    input  logic [NUM_LEVELS-1:0] pend_i,
    input  logic [ADDR_W-1:0]     sav_emu_i,
    input  logic [ADDR_W-1:0]     sav_nmi_i,
    input  logic [ADDR_W-1:0]     sav_exc_i,
    input  logic [ADDR_W-1:0]     sav_int_i,
    output logic [ADDR_W-1:0]     pc_o,
    output logic [NUM_LEVELS-1:0] pend_o,
    output logic                  pend_upd_o,
    output logic                  ret_done_o,
    output logic                  exc_o,
    output logic                  to_user_o,
    output logic                  recheck_o
);

    localparam int LVL_W = $clog2(NUM_LEVELS);
    localparam logic [NUM_LEVELS-1:0] GDIS_MASK = NUM_LEVELS'(1) << LV_GDIS;
    localparam logic [NUM_LEVELS-1:0] EMU_MASK  = NUM_LEVELS'(1) << LV_EMU;
    localparam logic [LVL_W-1:0]      L_RST     = LVL_W'(LV_RST);
    localparam logic [LVL_W-1:0]      L_FIRST_G = LVL_W'(LV_FIRST_G);

    typedef struct packed {
        logic [ADDR_W-1:0]     pc;
        logic [NUM_LEVELS-1:0] pend;
        logic                  upd;
        logic                  done;
        logic                  exc;
        logic                  user;
        logic                  recheck;
    } seq_state_t;

    seq_state_t st_d, st_q;

    ret_kind_e         kind;
    logic              lvl_found;
    logic [LVL_W-1:0]  cur_lvl;
    logic              ret_legal;
    logic [LVL_W-1:0]  tgt_lvl;
    logic [ADDR_W-1:0] saved_addr;

    assign kind = ret_kind_e'(ret_kind_i);

    evret_lvl_find #(.NUM_LEVELS(NUM_LEVELS)) u_lvl (
        .vec_i   (pend_i),
        .found_o (lvl_found),
        .idx_o   (cur_lvl)
    );

    evret_legal #(.NUM_LEVELS(NUM_LEVELS)) u_legal (
        .kind_i  (kind),
        .found_i (lvl_found),
        .lvl_i   (cur_lvl),
        .legal_o (ret_legal),
        .tgt_o   (tgt_lvl)
    );

    evret_src_sel #(.ADDR_W(ADDR_W)) u_sel (
        .kind_i (kind),
        .emu_i  (sav_emu_i),
        .nmi_i  (sav_nmi_i),
        .exc_i  (sav_exc_i),
        .int_i  (sav_int_i),
        .addr_o (saved_addr)
    );

    always_comb begin
        st_d         = st_q;
        st_d.upd     = 1'b0;
        st_d.done    = 1'b0;
        st_d.exc     = 1'b0;
        st_d.user    = 1'b0;
        st_d.recheck = 1'b0;
        if (ret_valid_i) begin
            if (ret_legal) begin
                st_d.pc    = {saved_addr[ADDR_W-1:1], 1'b0};
                st_d.pend  = pend_i & ~EMU_MASK;
                if (!saved_addr[0]) begin
                    st_d.pend[tgt_lvl] = 1'b0;
                end
                if ((tgt_lvl >= L_FIRST_G) || (tgt_lvl == L_RST)) begin
                    st_d.pend = st_d.pend & ~GDIS_MASK;
                end
                st_d.upd     = 1'b1;
                st_d.done    = 1'b1;
                st_d.recheck = 1'b1;
                st_d.user    = ((st_d.pend & ~GDIS_MASK) == '0);
            end else begin
                st_d.exc = 1'b1;
            end
        end else if (push_i) begin
            st_d.pend    = pend_i & ~GDIS_MASK;
            st_d.upd     = 1'b1;
            st_d.recheck = 1'b1;
        end else if (pop_i) begin
            st_d.pend = pend_i | GDIS_MASK;
            st_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o       = st_q.pc;
    assign pend_o     = st_q.pend;
    assign pend_upd_o = st_q.upd;
    assign ret_done_o = st_q.done;
    assign exc_o      = st_q.exc;
    assign to_user_o  = st_q.user;
    assign recheck_o  = st_q.recheck;

endmodule

// File: rtl/evret_seq_chk.sv
module evret_seq_chk
    import evret_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    parameter int ADDR_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ret_valid_i,
    input logic                  push_i,
    input logic                  pop_i,
    input logic [NUM_LEVELS-1:0] pend_i,
    input logic [ADDR_W-1:0]     pc_o,
    input logic [NUM_LEVELS-1:0] pend_o,
    input logic                  pend_upd_o,
    input logic                  ret_done_o,
    input logic                  exc_o,
    input logic                  to_user_o,
    input logic                  recheck_o
);

    localparam logic [NUM_LEVELS-1:0] GDIS_MASK = NUM_LEVELS'(1) << LV_GDIS;

    // R1: return at user level is refused
    a_r1_user_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && ((pend_i & ~GDIS_MASK) == '0)) |=> exc_o);

    // R5: new PC always has bit 0 clear
    a_r5_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done_o |-> !pc_o[0]);

    // R7: emulation bit cleared on completion
    a_r7_emu_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done_o |-> !pend_o[LV_EMU]);

    // R9: pop sets global disable without re-check
    a_r9_pop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !ret_valid_i) |=>
            (pend_upd_o && pend_o[LV_GDIS] && !recheck_o));

    // R9: push clears global disable and asks for re-check
    a_r9_push_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !ret_valid_i) |=>
            (pend_upd_o && !pend_o[LV_GDIS] && recheck_o));

    // R10: user strobe only with a completed return
    a_r10_user_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        to_user_o |-> ret_done_o);

    // R11: completion comes with re-check and write-back
    a_r11_recheck: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done_o |-> (recheck_o && pend_upd_o));

    // R12: refused return touches nothing else
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (!ret_done_o && !pend_upd_o && !recheck_o && !to_user_o));

    // R12: PC held across a refused return
    a_r12_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> $stable(pc_o));

endmodule

bind evret_seq evret_seq_chk #(.NUM_LEVELS(NUM_LEVELS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_valid_i (ret_valid_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .pend_i      (pend_i),
    .pc_o        (pc_o),
    .pend_o      (pend_o),
    .pend_upd_o  (pend_upd_o),
    .ret_done_o  (ret_done_o),
    .exc_o       (exc_o),
    .to_user_o   (to_user_o),
    .recheck_o   (recheck_o)
);

// File: tb/evret_seq_test.sv
`timescale 1ns/100ps
module evret_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid_i = 1'b0;
    logic [1:0]  ret_kind_i = 2'd0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [15:0] pend_i = '0;
    logic [31:0] sav_emu_i = '0;
    logic [31:0] sav_nmi_i = '0;
    logic [31:0] sav_exc_i = '0;
    logic [31:0] sav_int_i = '0;
    logic [31:0] pc_o;
    logic [15:0] pend_o;
    logic        pend_upd_o, ret_done_o, exc_o, to_user_o, recheck_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] e_pc = '0;
    logic [15:0] e_pend = '0;
    bit e_upd, e_done, e_exc, e_user, e_rchk;

    always #2.5 clk = ~clk;

    evret_seq uut (
        .clk(clk), .rst_n(rst_n), .ret_valid_i(ret_valid_i), .ret_kind_i(ret_kind_i),
        .push_i(push_i), .pop_i(pop_i), .pend_i(pend_i),
        .sav_emu_i(sav_emu_i), .sav_nmi_i(sav_nmi_i), .sav_exc_i(sav_exc_i),
        .sav_int_i(sav_int_i), .pc_o(pc_o), .pend_o(pend_o), .pend_upd_o(pend_upd_o),
        .ret_done_o(ret_done_o), .exc_o(exc_o), .to_user_o(to_user_o),
        .recheck_o(recheck_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "pc_o", pc_o, e_pc);
        chk(tag, "pend_o", {16'd0, pend_o}, {16'd0, e_pend});
        chk(tag, "pend_upd_o", {31'd0, pend_upd_o}, {31'd0, e_upd});
        chk(tag, "ret_done_o", {31'd0, ret_done_o}, {31'd0, e_done});
        chk(tag, "exc_o", {31'd0, exc_o}, {31'd0, e_exc});
        chk(tag, "to_user_o", {31'd0, to_user_o}, {31'd0, e_user});
        chk(tag, "recheck_o", {31'd0, recheck_o}, {31'd0, e_rchk});
    endtask

    // Behavioural reference: returns next expected outputs from one request
    task automatic model();
        int cur;
        int tgt;
        bit ok;
        logic [31:0] sv;
        logic [15:0] np;
        e_upd = 0; e_done = 0; e_exc = 0; e_user = 0; e_rchk = 0;
        if (ret_valid_i) begin
            cur = -1;
            for (int i = 0; i < 16; i++)
                if (i != 4 && pend_i[i] && cur < 0) cur = i;
            ok = 0; tgt = 0; sv = 0;
            case (ret_kind_i)
                2'd0: begin ok = (cur == 0); tgt = 0; sv = sav_emu_i; end
                2'd1: begin ok = (cur == 2); tgt = 2; sv = sav_nmi_i; end
                2'd2: begin ok = (cur == 3); tgt = 3; sv = sav_exc_i; end
                default: begin
                    ok = (cur >= 0) && cur != 0 && cur != 2 && cur != 3;
                    tgt = cur; sv = sav_int_i;
                end
            endcase
            if (ok) begin
                e_pc = sv & 32'hFFFF_FFFE;
                np = pend_i;
                np[0] = 1'b0;
                if (sv[0] == 1'b0) np[tgt] = 1'b0;
                if (tgt >= 5 || tgt == 1) np[4] = 1'b0;
                e_pend = np;
                e_upd = 1; e_done = 1; e_rchk = 1;
                e_user = ((np & 16'hFFEF) == 16'h0);
            end else begin
                e_exc = 1;
            end
        end else if (push_i) begin
            e_pend = pend_i & 16'hFFEF;
            e_upd = 1; e_rchk = 1;
        end else if (pop_i) begin
            e_pend = pend_i | 16'h0010;
            e_upd = 1;
        end
    endtask

    // Called on a falling edge: drive, step one clock, compare
    task automatic step(input string tag, input bit rv, input logic [1:0] k,
                        input bit pu, input bit po, input logic [15:0] pe,
                        input logic [31:0] saddr);
        ret_valid_i = rv; ret_kind_i = k; push_i = pu; pop_i = po; pend_i = pe;
        sav_emu_i = saddr ^ 32'h0000_1000;
        sav_nmi_i = saddr ^ 32'h0002_0000;
        sav_exc_i = saddr ^ 32'h0300_0000;
        sav_int_i = saddr;
        model();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        ret_valid_i = 0; push_i = 0; pop_i = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R14: reset state
        compare_all("R14");
        ret_valid_i = 1; pop_i = 1; pend_i = 16'h0001;
        @(posedge clk); @(negedge clk);
        compare_all("R14");
        ret_valid_i = 0; pop_i = 0;
        rst_n = 1'b1;
        @(negedge clk);
        step("R13", 0, 2'd0, 0, 0, 16'h0000, 32'h0);

        // R2 R4 R5 R7 R10: emulation return at level 0
        step("R2", 1, 2'd0, 0, 0, 16'h0001, 32'h0000_0100);
        // R2 R6 R8: NMI return, nesting bit kept, disable bit untouched
        step("R6", 1, 2'd1, 0, 0, 16'h0014, 32'h0000_2001);
        // R2 R8: exception return with higher level pending
        step("R8", 1, 2'd2, 0, 0, 16'h0818, 32'h0000_3000);
        // R3 R8: interrupt return from reset level clears disable
        step("R3", 1, 2'd3, 0, 0, 16'h0012, 32'h0000_4444);
        // R3 R6 R8: interrupt return from level 7, more pending
        step("R3", 1, 2'd3, 0, 0, 16'h8090, 32'h0000_5000);
        // R6: interrupt return from level 15 with nesting bit
        step("R6", 1, 2'd3, 0, 0, 16'h8010, 32'h0000_6001);
        // R10: last level left
        step("R10", 1, 2'd3, 0, 0, 16'h8010, 32'h0000_7000);
        // R1: return at user level
        step("R1", 1, 2'd3, 0, 0, 16'h0010, 32'h0000_8000);
        step("R1", 1, 2'd1, 0, 0, 16'h0000, 32'h0000_8000);
        // R2 R12: wrong kind for the current level
        step("R12", 1, 2'd0, 0, 0, 16'h0008, 32'h0000_9000);
        step("R12", 1, 2'd2, 0, 0, 16'h0080, 32'h0000_9000);
        // R3 R12: interrupt return at NMI and emulation levels
        step("R3", 1, 2'd3, 0, 0, 16'h0004, 32'h0000_A000);
        step("R3", 1, 2'd3, 0, 0, 16'h0021, 32'h0000_A000);
        // R9: push and pop
        step("R9", 0, 2'd0, 1, 0, 16'h0030, 32'h0);
        step("R9", 0, 2'd0, 0, 1, 16'h0020, 32'h0);
        // R13: precedence
        step("R13", 0, 2'd0, 1, 1, 16'h0070, 32'h0);
        step("R13", 1, 2'd3, 1, 1, 16'h0050, 32'h0000_B000);
        step("R13", 1, 2'd0, 0, 1, 16'h0040, 32'h0000_C000);
        step("R13", 0, 2'd0, 0, 0, 16'hFFFF, 32'h0);

        // R4 R11: mixed stimulus sweep
        for (int n = 0; n < 600; n++) begin
            int b;
            logic [15:0] pe;
            b = $urandom % 17;
            if (b == 16) pe = 16'($urandom) & 16'h0010;
            else pe = (16'h1 << b) | (16'($urandom) & (16'hFFFF << b)) |
                      (($urandom % 2) != 0 ? 16'h0010 : 16'h0000);
            step("R11", ($urandom % 3) != 0, 2'($urandom), ($urandom % 4) == 0,
                 ($urandom % 4) == 0, pe, $urandom);
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule